// File: doc/BRIEF.md
# Replication-Aware Victim Selector

This block chooses which way of one last-level cache set in a tile gives up its line, and says what must happen to the outgoing block. It is meant for a tiled many-core in which a directory tracks the sharers of each block, and in which a block may hold copies in several tiles' caches. The cache controller supplies the live status of every way of the addressed set: valid, replica, LRU age, block address and directory sharer count. The selector keeps one reference bit per way for every set on its own. A line access sets that bit, and the bits of a set are cleared together once all of them would be set.

A victim request returns a registered answer one cycle later: the way index, a disposition code and the home tile of the outgoing block. Replicas that have not been referenced recently are sacrificed first. A line that is the last copy on chip is forwarded to its home tile when this tile is not its home, and is written off chip when it already sits at home. A line with other sharers is simply dropped. The home tile is an XOR fold of the block address.

Top module: `repl_victim_sel`

## Requirements
- R1: If any way of the requested set is invalid, the victim is the lowest-index invalid way, and the disposition is 0 (nothing to evict).
- R2: With all ways valid, if any way is a replica whose reference bit is clear, the victim is the one among those with the largest LRU age (larger value means older). Ties go to the lowest index.
- R3: With all ways valid and no unreferenced replica, the victim is the way with the largest LRU age across all ways. Ties go to the lowest index.
- R4: An access strobe sets the reference bit of the accessed way in the accessed set, so that replica is no longer preferred by R2.
- R5: When an access would leave every reference bit of its set set, all reference bits of that set are cleared instead.
- R6: A valid victim whose sharer count is greater than 1 gets disposition 1 (drop silently).
- R7: A valid victim with sharer count 0 or 1 whose home tile differs from `tile_id` gets disposition 2 (forward to home). The home tile appears on `vout_home`.
- R8: A valid victim with sharer count 0 or 1 whose home tile equals `tile_id` gets disposition 3 (write off chip).
- R9: The home tile is the XOR of all block-address bits whose index has the same remainder modulo 4. Bit k of the 4-bit result folds address bits k, k+4, k+8 and so on. It is reported on `vout_home` for every valid victim.
- R10: `vout_valid` is high in exactly the cycle after a cycle with `vreq_valid` high, and low otherwise.
- R11: When an access and a victim request hit the same set in the same cycle, the selection uses the reference bits from before that access, and the access still takes effect.
- R12: Reset, synchronous and active high, clears every reference bit and drives `vout_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tile_id | input | 4 | Index of this tile |
| acc_valid | input | 1 | Line access strobe |
| acc_set | input | 4 | Set of the accessed line |
| acc_way | input | 3 | Way of the accessed line |
| vreq_valid | input | 1 | Victim request |
| vreq_set | input | 4 | Set for the victim request |
| way_valid | input | 8 | Valid bit per way |
| way_replica | input | 8 | Per way: line is a copy of a block also held elsewhere |
| way_age | input | 24 | LRU age per way, 3 bits each, way 0 in the low bits |
| way_sharers | input | 40 | Directory sharer count per way, 5 bits each |
| way_addr | input | 208 | Block address per way, 26 bits each |
| vout_valid | output | 1 | Victim result strobe |
| vout_way | output | 3 | Chosen way |
| vout_disp | output | 2 | 0 none, 1 drop, 2 forward home, 3 off chip |
| vout_home | output | 4 | Home tile of the victim block |

## Verification
A line access and a victim request can fall in the same cycle. When both target the same set, the reference update and the selection meet on one stored row. The bench provokes this in a directed case where the access would clear the set's bits through aging, and again many times in a random phase that confines traffic to four sets. Its behavioural model always selects from the row as it stood before the access, applies the access afterwards, and compares the result on every clock. A wrong ordering shows up as a different victim way, either in the same cycle or on the next request.

// File: rtl/rvs_pkg.sv
package rvs_pkg;
  typedef enum logic [1:0] {
    DISP_NONE    = 2'd0,
    DISP_DROP    = 2'd1,
    DISP_HOME    = 2'd2,
    DISP_OFFCHIP = 2'd3
  } disp_e;
endpackage

// File: rtl/rvs_home_hash.sv
module rvs_home_hash #(
  parameter int ADDR_W = 26,
  parameter int TILE_W = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [TILE_W-1:0] home
);
  // Fold the block address onto the tile index width by XOR.
  always_comb begin
    home = '0;
    for (int i = 0; i < ADDR_W; i++) begin
      home[i % TILE_W] = home[i % TILE_W] ^ addr[i];
    end
  end
endmodule

// File: rtl/rvs_ref_store.sv
module rvs_ref_store #(
  parameter int SETS = 16,
  parameter int WAYS = 8,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_valid,
  input  logic [SET_W-1:0] acc_set,
  input  logic [WAY_W-1:0] acc_way,
  input  logic [SET_W-1:0] rd_set,
  output logic [WAYS-1:0]  rd_refs
);
  logic [WAYS-1:0] rows [SETS];
  logic [WAYS-1:0] mark;
  logic [WAYS-1:0] merged;
  logic [WAYS-1:0] next_row;

  always_comb begin
    mark = '0;
    mark[acc_way] = 1'b1;
    merged = rows[acc_set] | mark;
    next_row = (&merged) ? '0 : merged;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) rows[s] <= '0;
    end else if (acc_valid) begin
      rows[acc_set] <= next_row;
    end
  end

  // Read returns the stored row, before any access in the same cycle.
  assign rd_refs = rows[rd_set];

  AST_REF_MARK: assert property (@(posedge clk) disable iff (rst)
    acc_valid && ($countones(rows[acc_set] | mark) < WAYS)
      |=> rows[$past(acc_set)][$past(acc_way)]); // R4

  AST_SET_NEVER_FULL: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> !(&rows[$past(acc_set)])); // R5
endmodule

// File: rtl/rvs_pick.sv
module rvs_pick #(
  parameter int WAYS  = 8,
  parameter int AGE_W = 3,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]       valid,
  input  logic [WAYS-1:0]       replica,
  input  logic [WAYS-1:0]       refs,
  input  logic [WAYS*AGE_W-1:0] age,
  output logic [WAY_W-1:0]      way
);
  logic [WAYS-1:0]  empty;
  logic [WAYS-1:0]  stale_copy;
  logic [WAYS-1:0]  pool;
  logic [AGE_W-1:0] best;
  logic [AGE_W-1:0] cur;
  logic             found;

  always_comb begin
    empty      = ~valid;
    stale_copy = valid & replica & ~refs;
    pool       = (|stale_copy) ? stale_copy : valid;
    way   = '0;
    best  = '0;
    cur   = '0;
    found = 1'b0;
    if (|empty) begin
      for (int i = 0; i < WAYS; i++) begin
        if (empty[i] && !found) begin
          way   = WAY_W'(i);
          found = 1'b1;
        end
      end
    end else begin
      for (int i = 0; i < WAYS; i++) begin
        cur = age[i*AGE_W +: AGE_W];
        if (pool[i] && (!found || cur > best)) begin
          way   = WAY_W'(i);
          best  = cur;
          found = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/repl_victim_sel.sv
module repl_victim_sel #(
  parameter int WAYS   = 8,
  parameter int SETS   = 16,
  parameter int AGE_W  = 3,
  parameter int CNT_W  = 5,
  parameter int ADDR_W = 26,
  parameter int TILES  = 16,
  localparam int WAY_W  = $clog2(WAYS),
  localparam int SET_W  = $clog2(SETS),
  localparam int TILE_W = $clog2(TILES)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [TILE_W-1:0]       tile_id,
  input  logic                    acc_valid,
  input  logic [SET_W-1:0]        acc_set,
  input  logic [WAY_W-1:0]        acc_way,
  input  logic                    vreq_valid,
  input  logic [SET_W-1:0]        vreq_set,
  input  logic [WAYS-1:0]         way_valid,
  input  logic [WAYS-1:0]         way_replica,
  input  logic [WAYS*AGE_W-1:0]   way_age,
  input  logic [WAYS*CNT_W-1:0]   way_sharers,
  input  logic [WAYS*ADDR_W-1:0]  way_addr,
  output logic                    vout_valid,
  output logic [WAY_W-1:0]        vout_way,
  output logic [1:0]              vout_disp,
  output logic [TILE_W-1:0]       vout_home
);
  import rvs_pkg::*;

  logic [WAYS-1:0]   set_refs;
  logic [WAY_W-1:0]  pick_way;
  logic [TILE_W-1:0] homes [WAYS];
  logic [TILE_W-1:0] home_sel;
  logic [CNT_W-1:0]  shr_sel;
  disp_e             disp;

  rvs_ref_store #(.SETS(SETS), .WAYS(WAYS)) u_refs (
    .clk(clk), .rst(rst),
    .acc_valid(acc_valid), .acc_set(acc_set), .acc_way(acc_way),
    .rd_set(vreq_set), .rd_refs(set_refs)
  );

  rvs_pick #(.WAYS(WAYS), .AGE_W(AGE_W)) u_pick (
    .valid(way_valid), .replica(way_replica), .refs(set_refs),
    .age(way_age), .way(pick_way)
  );

  for (genvar w = 0; w < WAYS; w++) begin : g_home
    rvs_home_hash #(.ADDR_W(ADDR_W), .TILE_W(TILE_W)) u_hash (
      .addr(way_addr[w*ADDR_W +: ADDR_W]),
      .home(homes[w])
    );
  end

  always_comb begin
    home_sel = homes[pick_way];
    shr_sel  = way_sharers[pick_way*CNT_W +: CNT_W];
    if (!way_valid[pick_way])        disp = DISP_NONE;
    else if (shr_sel > CNT_W'(1))    disp = DISP_DROP;
    else if (home_sel != tile_id)    disp = DISP_HOME;
    else                             disp = DISP_OFFCHIP;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vout_valid <= 1'b0;
      vout_way   <= '0;
      vout_disp  <= DISP_NONE;
      vout_home  <= '0;
    end else begin
      vout_valid <= vreq_valid;
      if (vreq_valid) begin
        vout_way  <= pick_way;
        vout_disp <= disp;
        vout_home <= home_sel;
      end
    end
  end

  AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    vreq_valid |=> vout_valid); // R10

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    !vreq_valid |=> !vout_valid); // R10

  AST_EMPTY_FIRST: assert property (@(posedge clk) disable iff (rst)
    vreq_valid && !(&way_valid) |=> vout_disp == DISP_NONE); // R1

  AST_SHARED_DROP: assert property (@(posedge clk) disable iff (rst)
    vreq_valid && way_valid[pick_way] && (shr_sel > CNT_W'(1))
      |=> vout_disp == DISP_DROP); // R6

  AST_FWD_REMOTE: assert property (@(posedge clk) disable iff (rst)
    vout_valid && vout_disp == DISP_HOME |-> vout_home != $past(tile_id)); // R7

  AST_OFFCHIP_LOCAL: assert property (@(posedge clk) disable iff (rst)
    vout_valid && vout_disp == DISP_OFFCHIP |-> vout_home == $past(tile_id)); // R8
endmodule

// File: tb/repl_victim_sel_test.sv
module repl_victim_sel_test;
  localparam int CLK_PERIOD = 10;
  localparam int WAYS = 8, SETS = 16, AGE_W = 3, CNT_W = 5, ADDR_W = 26;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] tile_id = '0;
  logic acc_valid = 1'b0;
  logic [3:0] acc_set = '0;
  logic [2:0] acc_way = '0;
  logic vreq_valid = 1'b0;
  logic [3:0] vreq_set = '0;
  logic [WAYS-1:0] way_valid = '0, way_replica = '0;
  logic [WAYS*AGE_W-1:0] way_age = '0;
  logic [WAYS*CNT_W-1:0] way_sharers = '0;
  logic [WAYS*ADDR_W-1:0] way_addr = '0;
  logic vout_valid;
  logic [2:0] vout_way;
  logic [1:0] vout_disp;
  logic [3:0] vout_home;

  repl_victim_sel uut (
    .clk(clk), .rst(rst), .tile_id(tile_id),
    .acc_valid(acc_valid), .acc_set(acc_set), .acc_way(acc_way),
    .vreq_valid(vreq_valid), .vreq_set(vreq_set),
    .way_valid(way_valid), .way_replica(way_replica), .way_age(way_age),
    .way_sharers(way_sharers), .way_addr(way_addr),
    .vout_valid(vout_valid), .vout_way(vout_way),
    .vout_disp(vout_disp), .vout_home(vout_home)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0;
  int checks = 0;
  int m_ref [SETS];
  bit v [WAYS];
  bit rp [WAYS];
  int ag [WAYS];
  int sh [WAYS];
  logic [ADDR_W-1:0] ad [WAYS];

  function automatic logic [3:0] fold(input logic [ADDR_W-1:0] a);
    logic [3:0] h = '0;
    for (int i = 0; i < ADDR_W; i++) h[i % 4] ^= a[i];
    return h;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic load_inputs();
    for (int w = 0; w < WAYS; w++) begin
      way_valid[w] = v[w];
      way_replica[w] = rp[w];
      way_age[w*AGE_W +: AGE_W] = AGE_W'(ag[w]);
      way_sharers[w*CNT_W +: CNT_W] = CNT_W'(sh[w]);
      way_addr[w*ADDR_W +: ADDR_W] = ad[w];
    end
  endtask

  // One cycle: drive, predict from the model, advance, compare.
  task automatic step(input bit a_en, input int a_set, input int a_way,
                      input bit r_en, input int r_set, input string ph);
    int ew = 0;
    int best = -1;
    int ed;
    bit any_inv = 0, any_stale = 0;
    string wtag;
    logic [3:0] eh;
    load_inputs();
    acc_valid = a_en; acc_set = 4'(a_set); acc_way = 3'(a_way);
    vreq_valid = r_en; vreq_set = 4'(r_set);
    for (int w = 0; w < WAYS; w++) begin
      if (!v[w]) any_inv = 1;
      if (v[w] && rp[w] && !m_ref[r_set][w]) any_stale = 1;
    end
    if (any_inv) begin
      wtag = "R1";
      for (int w = WAYS-1; w >= 0; w--) if (!v[w]) ew = w;
    end else begin
      wtag = any_stale ? "R2" : "R3";
      for (int w = 0; w < WAYS; w++)
        if ((!any_stale || (rp[w] && !m_ref[r_set][w])) && ag[w] > best) begin
          best = ag[w]; ew = w;
        end
    end
    eh = fold(ad[ew]);
    if (!v[ew]) ed = 0;
    else if (sh[ew] > 1) ed = 1;
    else if (eh != tile_id) ed = 2;
    else ed = 3;
    // Model update after the selection (R11 ordering).
    if (a_en) begin
      m_ref[a_set] |= (1 << a_way);
      if (m_ref[a_set] == (1 << WAYS) - 1) m_ref[a_set] = 0;
    end
    @(posedge clk);
    @(negedge clk);
    check(vout_valid == r_en, {ph, " R10 valid"}, int'(vout_valid), int'(r_en));
    if (r_en) begin
      check(vout_way == 3'(ew), {ph, " ", wtag, " way"}, int'(vout_way), ew);
      check(vout_disp == 2'(ed),
            {ph, ed == 1 ? " R6" : ed == 2 ? " R7" : ed == 3 ? " R8" : " R1", " disp"},
            int'(vout_disp), ed);
      if (ed != 0) check(vout_home == eh, {ph, " R9 home"}, int'(vout_home), int'(eh));
    end
    acc_valid = 0; vreq_valid = 0;
  endtask

  task automatic do_reset();
    rst = 1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst = 0;
    for (int s = 0; s < SETS; s++) m_ref[s] = 0;
    check(vout_valid == 0, "R12 reset valid", int'(vout_valid), 0);
  endtask

  task automatic base_set();
    for (int w = 0; w < WAYS; w++) begin
      v[w] = 1; rp[w] = 0; ag[w] = w % 8; sh[w] = 2;
      ad[w] = ADDR_W'(32'h0100_0000 + w * 32'h11);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int s = 0; s < SETS; s++) m_ref[s] = 0;
    @(negedge clk);
    do_reset();
    tile_id = 4'd5;

    // R1: invalid ways first, lowest index
    base_set(); v[5] = 0; v[2] = 0;
    step(0, 0, 0, 1, 0, "R1 invalid");
    // R3: oldest, then tie on lowest index
    base_set();
    step(0, 0, 0, 1, 0, "R3 oldest");
    ag[3] = 7;
    step(0, 0, 0, 1, 0, "R3 tie");
    // R2: stale replica beats older plain line
    base_set(); rp[1] = 1; rp[4] = 1; sh[4] = 1;
    step(0, 0, 0, 1, 0, "R2 replica");
    // R4: referencing way 4 moves choice to way 1
    step(1, 0, 4, 0, 0, "R4 access");
    step(0, 0, 0, 1, 0, "R4 referenced");
    // R7 / R8 dispositions
    base_set(); sh[7] = 1;
    tile_id = fold(ad[7]) ^ 4'd1;
    step(0, 0, 0, 1, 0, "R7 forward");
    tile_id = fold(ad[7]);
    step(0, 0, 0, 1, 0, "R8 offchip");
    sh[7] = 0;
    step(0, 0, 0, 1, 0, "R8 zero sharers");
    // R5: filling set 3 clears it
    base_set(); rp[2] = 1;
    for (int w = 0; w < WAYS-1; w++) step(1, 3, w, 0, 0, "R5 fill");
    step(0, 0, 0, 1, 3, "R5 before");
    // R11: last access clears bits while request reads old row
    step(1, 3, 7, 1, 3, "R11 same cycle");
    step(0, 0, 0, 1, 3, "R5 after clear");
    // R12: reset clears reference bits
    step(1, 6, 2, 0, 0, "R12 prep");
    do_reset();
    step(0, 0, 0, 1, 6, "R12 cleared");

    // Random traffic on four sets
    for (int n = 0; n < 600; n++) begin
      if (n % 50 == 0) tile_id = 4'($urandom_range(0, 15));
      for (int w = 0; w < WAYS; w++) begin
        v[w] = ($urandom_range(0, 15) != 0);
        rp[w] = $urandom_range(0, 1);
        ag[w] = $urandom_range(0, 7);
        sh[w] = $urandom_range(0, 3);
        ad[w] = ADDR_W'($urandom);
      end
      step($urandom_range(0, 3) != 0, $urandom_range(0, 3), $urandom_range(0, 7),
           $urandom_range(0, 1), $urandom_range(0, 3), "R11 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule